// File: doc/BRIEF.md
# Multichannel Overflow Flag Controller

This block gathers the over-range indications from eight converter input channels and reports them in one of two ways. A mode input picks the way. In pin mode, a single active-low flag is modelled as an open-drain pull-down enable. The flag asserts in the same cycle that any channel reports an over-range. It then stays asserted for a fixed hold window, and any new over-range restarts that window.

In register mode, each channel has its own sticky status bit. The host clears a status bit by writing 1 to it. A per-channel mask picks which status bits may raise an active-high interrupt. A small register port, with a combinational read and a single-cycle write, gives access to the status and mask registers. A synchronous reset returns everything to idle.

Top module: `ovfl_flag_ctrl`

## Requirements
- R1: In pin mode (`regMode`=0), `ovflDriveLow` is 1 in the same cycle that any bit of `overRange` is 1.
- R2: After the last cycle with an over-range, `ovflDriveLow` stays 1 for exactly `HOLD_CYCLES` further cycles, then returns to 0.
- R3: An over-range on any channel while the flag is held restarts the hold window, counted from that cycle.
- R4: In register mode, `ovflDriveLow` is 0. In pin mode, `irq` is 0 and no status bit is set by an over-range.
- R5: In register mode, an over-range on channel k sets status bit k on the next clock edge, and the bit stays set.
- R6: Writing 1 to a status bit clears it on the next edge, and writing 0 leaves it unchanged. If an over-range on that channel arrives in the same cycle as the clear, the bit stays set.
- R7: In register mode, `irq` is 1 exactly when some channel has both its status bit and its mask bit set. The mask resets to all zeros.
- R8: Register map: address 0x02 is status (read, write-1-to-clear), bit k = channel k. Address 0x03 is mask (read/write), bit k = channel k. Other addresses read 0, and writes to them have no effect.
- R9: A synchronous reset (`rst`=1) clears the hold counter, releases `ovflDriveLow`, and clears the status and mask registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| regMode | input | 1 | 0 = pin reporting, 1 = register reporting |
| overRange | input | NUM_CH | Per-channel over-range indication |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address |
| wrData | input | NUM_CH | Register write data |
| rdData | output | NUM_CH | Register read data (combinational) |
| ovflDriveLow | output | 1 | Open-drain enable: 1 pulls the overflow flag low |
| irq | output | 1 | Masked interrupt, active high |

## Verification
The bench first lets the flag run out and then retriggers it partway through the hold window. A design that ignored the restart would release the flag a few cycles into the second window. A design with an off-by-one counter would release it one cycle early or late. A status write of 1 is aimed at a channel that reports an over-range in the same cycle; a design that lets the clear win would lose that event. The bench also writes to an unmapped address, checks that pin mode neither latches status nor raises the interrupt, and resets the block in the middle of a hold window to catch a counter that survives reset.

// File: rtl/ovfl_pkg.sv
package ovfl_pkg;
  typedef struct packed {
    logic captureEn;
    logic wrStatus;
    logic wrMask;
    logic selStatus;
    logic selMask;
  } ovflStb_t;
endpackage

// File: rtl/ovfl_ctrl.sv
module ovfl_ctrl
  import ovfl_pkg::*;
#(
  parameter int HOLD_CYCLES = 16384,
  parameter int ADDR_W      = 8,
  parameter int STATUS_ADDR = 2,
  parameter int MASK_ADDR   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regMode,
  input  logic              anyOvr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ovflStb_t          stb,
  output logic              holdLow
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic             holdActive;
  logic [CNT_W-1:0] holdCnt;

  // restartable hold window; counts cycles after the latest over-range
  always_ff @(posedge clk) begin
    if (rst) begin
      holdActive <= 1'b0;
      holdCnt    <= '0;
    end else if (!regMode && anyOvr) begin
      holdActive <= 1'b1;
      holdCnt    <= '0;
    end else if (holdActive) begin
      if (holdCnt == LAST) begin
        holdActive <= 1'b0;
        holdCnt    <= '0;
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end

  assign holdLow = !regMode && (anyOvr || holdActive);

  always_comb begin
    stb.captureEn = regMode;
    stb.selStatus = (regAddr == ADDR_W'(STATUS_ADDR));
    stb.selMask   = (regAddr == ADDR_W'(MASK_ADDR));
    stb.wrStatus  = wrEn && stb.selStatus;
    stb.wrMask    = wrEn && stb.selMask;
  end
endmodule

// File: rtl/ovfl_regs.sv
module ovfl_regs
  import ovfl_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ovflStb_t          stb,
  input  logic [NUM_CH-1:0] overRange,
  input  logic [NUM_CH-1:0] wrData,
  output logic [NUM_CH-1:0] rdData,
  output logic [NUM_CH-1:0] statusVec,
  output logic [NUM_CH-1:0] maskVec,
  output logic              irq
);
  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    // set has priority over write-1-to-clear
    always_ff @(posedge clk) begin
      if (rst)                                statusVec[g] <= 1'b0;
      else if (stb.captureEn && overRange[g]) statusVec[g] <= 1'b1;
      else if (stb.wrStatus && wrData[g])     statusVec[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             maskVec <= '0;
    else if (stb.wrMask) maskVec <= wrData;
  end

  always_comb begin
    if (stb.selStatus)    rdData = statusVec;
    else if (stb.selMask) rdData = maskVec;
    else                  rdData = '0;
  end

  assign irq = stb.captureEn && |(statusVec & maskVec);
endmodule

// File: rtl/ovfl_flag_ctrl.sv
module ovfl_flag_ctrl
  import ovfl_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int HOLD_CYCLES = 16384,
  parameter int ADDR_W      = 8,
  parameter int STATUS_ADDR = 2,
  parameter int MASK_ADDR   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regMode,
  input  logic [NUM_CH-1:0] overRange,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [NUM_CH-1:0] wrData,
  output logic [NUM_CH-1:0] rdData,
  output logic              ovflDriveLow,
  output logic              irq
);
  ovflStb_t          stb;
  logic [NUM_CH-1:0] statusVec;
  logic [NUM_CH-1:0] maskVec;

  ovfl_ctrl #(
    .HOLD_CYCLES(HOLD_CYCLES), .ADDR_W(ADDR_W),
    .STATUS_ADDR(STATUS_ADDR), .MASK_ADDR(MASK_ADDR)
  ) uCtrl (
    .clk(clk), .rst(rst), .regMode(regMode), .anyOvr(|overRange),
    .wrEn(wrEn), .regAddr(regAddr), .stb(stb), .holdLow(ovflDriveLow)
  );

  ovfl_regs #(.NUM_CH(NUM_CH)) uRegs (
    .clk(clk), .rst(rst), .stb(stb), .overRange(overRange),
    .wrData(wrData), .rdData(rdData), .statusVec(statusVec),
    .maskVec(maskVec), .irq(irq)
  );
endmodule

// File: rtl/ovfl_flag_chk.sv
module ovfl_flag_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              regMode,
  input logic [NUM_CH-1:0] overRange,
  input logic              ovflDriveLow,
  input logic              irq,
  input logic [NUM_CH-1:0] statusVec,
  input logic [NUM_CH-1:0] maskVec
);
  a_r1_immediate_low: assert property (@(posedge clk) disable iff (rst)
    (!regMode && |overRange) |-> ovflDriveLow);

  a_r2_held_after_event: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !regMode && $past(!regMode) && $past(|overRange)) |-> ovflDriveLow);

  a_r4_reg_mode_released: assert property (@(posedge clk) disable iff (rst)
    regMode |-> !ovflDriveLow);

  a_r4_pin_mode_no_irq: assert property (@(posedge clk) disable iff (rst)
    !regMode |-> !irq);

  a_r5_sticky_capture: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(regMode)) |-> ((statusVec & $past(overRange)) == $past(overRange)));

  a_r6_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((statusVec & ~$past(statusVec) & ~$past(overRange)) == '0));

  a_r7_irq_needs_both: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((statusVec & maskVec) != '0));

  a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (statusVec == '0 && maskVec == '0));
endmodule

bind ovfl_flag_ctrl ovfl_flag_chk #(.NUM_CH(NUM_CH)) uChk (.*);

// File: tb/sim_ovfl_flag_ctrl.sv
module sim_ovfl_flag_ctrl;
  localparam int HOLD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       regMode = 1'b1;
  logic [7:0] overRange = '0;
  logic       wrEn = 1'b0;
  logic [7:0] regAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       ovflDriveLow;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ovfl_flag_ctrl #(.HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .rst(rst), .regMode(regMode), .overRange(overRange),
    .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData), .rdData(rdData),
    .ovflDriveLow(ovflDriveLow), .irq(irq)
  );

  typedef struct packed {
    logic       m;
    logic [7:0] ovr;
    logic       we;
    logic [7:0] addr;
    logic [7:0] wd;
    logic [7:0] expRd;
    logic       expIrq;
    logic       expLow;
  } vec_t;

  // expected values are those seen before the row's clock edge
  localparam vec_t VECS [16] = '{
    '{1'b1, 8'h00, 1'b0, 8'h02, 8'h00, 8'h00, 1'b0, 1'b0}, // R5 idle
    '{1'b1, 8'h05, 1'b0, 8'h02, 8'h00, 8'h00, 1'b0, 1'b0}, // R5 capture ch0,ch2
    '{1'b1, 8'h00, 1'b0, 8'h02, 8'h00, 8'h05, 1'b0, 1'b0}, // R5 sticky, R7 masked
    '{1'b1, 8'h00, 1'b1, 8'h03, 8'h04, 8'h00, 1'b0, 1'b0}, // R8 mask write
    '{1'b1, 8'h00, 1'b0, 8'h03, 8'h00, 8'h04, 1'b1, 1'b0}, // R7 irq on ch2
    '{1'b1, 8'h00, 1'b1, 8'h02, 8'h04, 8'h05, 1'b1, 1'b0}, // R6 clear ch2
    '{1'b1, 8'h00, 1'b0, 8'h02, 8'h00, 8'h01, 1'b0, 1'b0}, // R6 cleared
    '{1'b1, 8'h80, 1'b1, 8'h02, 8'h80, 8'h01, 1'b0, 1'b0}, // R6 set beats clear
    '{1'b1, 8'h01, 1'b1, 8'h02, 8'h01, 8'h81, 1'b0, 1'b0}, // R6 set beats clear
    '{1'b1, 8'h00, 1'b0, 8'h02, 8'h00, 8'h81, 1'b0, 1'b0}, // R6 both kept
    '{1'b1, 8'h00, 1'b1, 8'h07, 8'hFF, 8'h00, 1'b0, 1'b0}, // R8 unmapped
    '{1'b1, 8'h00, 1'b0, 8'h03, 8'h00, 8'h04, 1'b0, 1'b0}, // R8 mask untouched
    '{1'b0, 8'h02, 1'b0, 8'h02, 8'h00, 8'h81, 1'b0, 1'b1}, // R4 pin mode
    '{1'b1, 8'h00, 1'b0, 8'h02, 8'h00, 8'h81, 1'b0, 1'b0}, // R4 no capture
    '{1'b1, 8'h00, 1'b1, 8'h03, 8'h81, 8'h04, 1'b0, 1'b0}, // R7 remask
    '{1'b1, 8'h00, 1'b0, 8'h03, 8'h00, 8'h81, 1'b1, 1'b0}  // R7 irq
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic m, input logic [7:0] ovr, input logic we,
                       input logic [7:0] addr, input logic [7:0] wd);
    @(negedge clk);
    regMode = m; overRange = ovr; wrEn = we; regAddr = addr; wrData = wd;
    #1;
  endtask

  task automatic pinCyc(input logic [7:0] ovr, input logic expLow, input string req);
    drive(1'b0, ovr, 1'b0, 8'h00, 8'h00);
    chk(req, 32'(ovflDriveLow), 32'(expLow));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    drive(1'b1, 8'h00, 1'b0, 8'h02, 8'h00);
    chk("R9 status", 32'(rdData), 32'h0);
    chk("R9 irq", 32'(irq), 32'h0);
    drive(1'b0, 8'h00, 1'b0, 8'h03, 8'h00);
    chk("R9 mask", 32'(rdData), 32'h0);
    chk("R9 pin", 32'(ovflDriveLow), 32'h0);

    foreach (VECS[i]) begin
      drive(VECS[i].m, VECS[i].ovr, VECS[i].we, VECS[i].addr, VECS[i].wd);
      chk($sformatf("R8 rd row %0d", i), 32'(rdData), 32'(VECS[i].expRd));
      chk($sformatf("R7 irq row %0d", i), 32'(irq), 32'(VECS[i].expIrq));
      chk($sformatf("R4 pin row %0d", i), 32'(ovflDriveLow), 32'(VECS[i].expLow));
    end

    // let the hold window from the table run out
    for (int k = 0; k < HOLD + 2; k++) drive(1'b0, 8'h00, 1'b0, 8'h00, 8'h00);
    pinCyc(8'h00, 1'b0, "R2 idle");

    // R1 and R2: one pulse, exact window length
    pinCyc(8'h10, 1'b1, "R1 immediate");
    for (int k = 1; k <= HOLD; k++) pinCyc(8'h00, 1'b1, "R2 held");
    pinCyc(8'h00, 1'b0, "R2 release");

    // R3: retrigger inside the window from another channel
    pinCyc(8'h01, 1'b1, "R1 immediate ch0");
    for (int k = 0; k < 5; k++) pinCyc(8'h00, 1'b1, "R3 first window");
    pinCyc(8'h40, 1'b1, "R3 retrigger");
    for (int k = 1; k <= HOLD; k++) pinCyc(8'h00, 1'b1, "R3 restarted");
    pinCyc(8'h00, 1'b0, "R3 release");

    // R4: pin mode never raises irq
    drive(1'b0, 8'h00, 1'b0, 8'h02, 8'h00);
    chk("R4 irq in pin mode", 32'(irq), 32'h0);

    // R9: reset in the middle of a hold window with live status and mask
    pinCyc(8'h08, 1'b1, "R1 before reset");
    drive(1'b0, 8'h00, 1'b0, 8'h00, 8'h00);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R9 pin released", 32'(ovflDriveLow), 32'h0);
    drive(1'b1, 8'h00, 1'b0, 8'h02, 8'h00);
    chk("R9 status cleared", 32'(rdData), 32'h0);
    drive(1'b1, 8'h00, 1'b0, 8'h03, 8'h00);
    chk("R9 mask cleared", 32'(rdData), 32'h0);
    pinCyc(8'h00, 1'b0, "R9 counter cleared");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule